// File: doc/BRIEF.md
# Staggered Half-Word Integer ALU

This block is a 32-bit integer ALU that runs on the fast clock, which is twice the main clock. It does its work in two 16-bit slices on consecutive fast cycles. An operation issued at one edge has its low half registered at that edge. The high half follows one fast cycle later and uses the carry out of the low slice. Carry, zero, sign and overflow flags follow one cycle after that. Because the low half comes out first, a dependent operation can issue on the very next fast cycle. It picks up the low half of its producer, and it reads the high half of its operands one cycle after issue, when the producer's high half is ready. A chain of dependent additions therefore advances at one fast cycle per operation.

Each operand comes through its own four-way bypass multiplexer. The four sources are this ALU's own latest result, the result of the peer ALU, the data-cache load result and the registered output of the deeper bypass network. The low half of an operand is taken from the selected source at issue and the high half one cycle later.

The adder can invert the B operand and take a carry-in, which gives subtraction. A three-bit mask can cut the carry chain at any byte boundary, so packed byte arithmetic is possible. The block also provides the bitwise logic functions, byte and half-word sign extension, and a pass-through.

Top module: `stag_alu`

## Requirements
- R1: An operation sampled with `in_valid` high at a clock edge drives `lo_valid` high and `lo_res` to bits 15:0 of its result after that same edge.
- R2: `hi_res` carries bits 31:16 of the result, with `hi_valid` high, one cycle after the low half. It adds the carry out of bit 15, and its operand high halves are read from the sources one cycle after issue.
- R3: The flags appear with `flg_valid` one cycle after the high half. C is the carry out of bit 31. Z is set only when both halves are zero. N is bit 31. V is the carry into bit 31 XOR the carry out of bit 31. C and V are 0 for every opcode other than add.
- R4: Source select 0 returns this ALU's own latest low half at issue and its own latest high half one cycle later. With it, dependent operations issued on consecutive cycles chain correctly, and a new operation may issue every cycle.
- R5: When `in_inv_b` is 1, B is inverted before the add or logic function. `in_cin` is the carry into bit 0.
- R6: `in_blk[i]` set to 1 cuts the carry between byte lane i and lane i+1. The upper lane then takes `in_cin` as its carry-in. Bit 1 is the boundary between the two halves.
- R7: Opcodes 1, 2 and 3 give A AND B, A OR B and A XOR B. Opcode 0 is add.
- R8: Opcode 4 sign-extends bits 7:0 of A to 32 bits, and opcode 5 sign-extends bits 15:0 of A.
- R9: Opcode 6 passes A unchanged. The source select encoding is 0 own result, 1 peer ALU, 2 data-cache load, 3 deep bypass, and it applies to A and B alike.
- R10: During reset all valid outputs, result halves and flags are 0.
- R11: Result halves and flags hold their last values while no operation occupies their stage, whatever the source inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue an operation this cycle |
| in_op | input | 3 | Opcode |
| in_inv_b | input | 1 | Invert operand B |
| in_cin | input | 1 | Carry into bit 0 and into every blocked lane |
| in_blk | input | 3 | Carry cut mask, one bit per byte boundary |
| in_sel_a | input | 2 | Bypass source for A |
| in_sel_b | input | 2 | Bypass source for B |
| peer_res | input | 32 | Result of the peer ALU |
| load_res | input | 32 | Data-cache load result |
| deep_res | input | 32 | Registered deep bypass network output |
| lo_valid | output | 1 | Low half valid |
| lo_res | output | 16 | Result bits 15:0 |
| hi_valid | output | 1 | High half valid |
| hi_res | output | 16 | Result bits 31:16 |
| flg_valid | output | 1 | Flags valid |
| flg_c | output | 1 | Carry flag |
| flg_z | output | 1 | Zero flag |
| flg_n | output | 1 | Sign flag |
| flg_v | output | 1 | Overflow flag |

## Verification
The bench builds the block with its default parameters: 16-bit halves and 8-bit lanes. That gives two byte lanes in each half, so each of the three carry cut bits can be reached, including the half boundary that sits between the two pipeline stages. With these widths, hand-computed values show carries crossing from the low slice into the high slice. They also show the zero flag staying clear when only one half is zero. A three-deep chain that takes operands from the ALU's own result confirms that the low and high halves of a producer are both picked up at the right cycles.

// File: rtl/stag_alu_pkg.sv
package stag_alu_pkg;

    // Opcode values
    localparam logic [2:0] OP_ADD  = 3'd0;
    localparam logic [2:0] OP_AND  = 3'd1;
    localparam logic [2:0] OP_OR   = 3'd2;
    localparam logic [2:0] OP_XOR  = 3'd3;
    localparam logic [2:0] OP_SX8  = 3'd4;
    localparam logic [2:0] OP_SX16 = 3'd5;
    localparam logic [2:0] OP_PASS = 3'd6;

    // Bypass source encoding
    typedef enum logic [1:0] {
        SRC_SELF = 2'd0,
        SRC_PEER = 2'd1,
        SRC_LOAD = 2'd2,
        SRC_DEEP = 2'd3
    } src_e;

endpackage

// File: rtl/stag_alu_mux.sv
module stag_alu_mux
    import stag_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [1:0]   sel_i,
    input  logic [W-1:0] self_i,
    input  logic [W-1:0] peer_i,
    input  logic [W-1:0] load_i,
    input  logic [W-1:0] deep_i,
    output logic [W-1:0] out_o
);

    always_comb begin
        case (src_e'(sel_i))
            SRC_SELF: out_o = self_i;
            SRC_PEER: out_o = peer_i;
            SRC_LOAD: out_o = load_i;
            default:  out_o = deep_i;
        endcase
    end

endmodule

// File: rtl/stag_alu_slice.sv
module stag_alu_slice
    import stag_alu_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int LANE_W = 8,
    parameter bit IS_LO  = 1'b1
) (
    input  logic [HALF_W-1:0]        a_i,
    input  logic [HALF_W-1:0]        b_i,
    input  logic [2:0]               op_i,
    input  logic                     inv_i,
    input  logic                     cin_op_i,
    input  logic                     cin_ext_i,
    input  logic [HALF_W/LANE_W-1:0] blk_i,
    input  logic                     sgn_i,
    output logic [HALF_W-1:0]        res_o,
    output logic                     cout_o
);

    localparam int LPH = HALF_W / LANE_W;

    logic [HALF_W-1:0] bx;
    logic [HALF_W-1:0] sum;
    logic [HALF_W-1:0] sext;
    logic [LPH:0]      lane_c;
    logic [LPH-1:0]    lane_in;

    assign bx        = inv_i ? ~b_i : b_i;
    assign lane_c[0] = cin_ext_i;
    assign cout_o    = lane_c[LPH];

    // One adder per byte lane; a cut boundary feeds the operation carry-in
    for (genvar j = 0; j < LPH; j++) begin : g_lane
        assign lane_in[j] = blk_i[j] ? cin_op_i : lane_c[j];
        assign {lane_c[j+1], sum[j*LANE_W +: LANE_W]} =
            {1'b0, a_i[j*LANE_W +: LANE_W]} +
            {1'b0, bx[j*LANE_W +: LANE_W]} +
            {{LANE_W{1'b0}}, lane_in[j]};
    end

    // Sign extension differs between the low and the high slice
    if (IS_LO) begin : g_sext_lo
        assign sext = (op_i == OP_SX8)
                    ? {{(HALF_W-LANE_W){sgn_i}}, a_i[LANE_W-1:0]}
                    : a_i;
    end else begin : g_sext_hi
        assign sext = {HALF_W{sgn_i}};
    end

    always_comb begin
        case (op_i)
            OP_ADD:  res_o = sum;
            OP_AND:  res_o = a_i & bx;
            OP_OR:   res_o = a_i | bx;
            OP_XOR:  res_o = a_i ^ bx;
            OP_SX8,
            OP_SX16: res_o = sext;
            default: res_o = a_i;
        endcase
    end

endmodule

// File: rtl/stag_alu.sv
module stag_alu
    import stag_alu_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int LANE_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic [2:0]                        in_op,
    input  logic                              in_inv_b,
    input  logic                              in_cin,
    input  logic [2*(HALF_W/LANE_W)-2:0]      in_blk,
    input  logic [1:0]                        in_sel_a,
    input  logic [1:0]                        in_sel_b,
    input  logic [2*HALF_W-1:0]               peer_res,
    input  logic [2*HALF_W-1:0]               load_res,
    input  logic [2*HALF_W-1:0]               deep_res,
    output logic                              lo_valid,
    output logic [HALF_W-1:0]                 lo_res,
    output logic                              hi_valid,
    output logic [HALF_W-1:0]                 hi_res,
    output logic                              flg_valid,
    output logic                              flg_c,
    output logic                              flg_z,
    output logic                              flg_n,
    output logic                              flg_v
);

    localparam int WORD_W = 2 * HALF_W;
    localparam int LPH    = HALF_W / LANE_W;
    localparam int NLANE  = 2 * LPH;
    localparam int MSB    = HALF_W - 1;

    typedef struct packed {
        logic              v;
        logic [2:0]        op;
        logic              inv;
        logic              cin;
        logic [LPH-1:0]    blk_hi;
        logic [1:0]        sa;
        logic [1:0]        sb;
        logic              sgn;
        logic              cout;
        logic [HALF_W-1:0] res;
    } st1_t;

    typedef struct packed {
        logic              v;
        logic [2:0]        op;
        logic              lo_zero;
        logic              c_out;
        logic              c_msb;
        logic [HALF_W-1:0] res;
    } st2_t;

    typedef struct packed {
        logic v;
        logic c;
        logic z;
        logic n;
        logic ov;
    } st3_t;

    typedef struct packed {
        st1_t s1;
        st2_t s2;
        st3_t s3;
    } pipe_t;

    pipe_t q, d;

    logic [HALF_W-1:0] a_lo, b_lo, a_hi, b_hi;
    logic [HALF_W-1:0] lo_sum, hi_sum;
    logic              lo_cout, hi_cout;
    logic              arith;

    // Operand muxes: low halves at issue, high halves one cycle later
    stag_alu_mux #(.W(HALF_W)) u_mux_a_lo (
        .sel_i(in_sel_a), .self_i(q.s1.res),
        .peer_i(peer_res[HALF_W-1:0]), .load_i(load_res[HALF_W-1:0]),
        .deep_i(deep_res[HALF_W-1:0]), .out_o(a_lo)
    );
    stag_alu_mux #(.W(HALF_W)) u_mux_b_lo (
        .sel_i(in_sel_b), .self_i(q.s1.res),
        .peer_i(peer_res[HALF_W-1:0]), .load_i(load_res[HALF_W-1:0]),
        .deep_i(deep_res[HALF_W-1:0]), .out_o(b_lo)
    );
    stag_alu_mux #(.W(HALF_W)) u_mux_a_hi (
        .sel_i(q.s1.sa), .self_i(q.s2.res),
        .peer_i(peer_res[WORD_W-1:HALF_W]), .load_i(load_res[WORD_W-1:HALF_W]),
        .deep_i(deep_res[WORD_W-1:HALF_W]), .out_o(a_hi)
    );
    stag_alu_mux #(.W(HALF_W)) u_mux_b_hi (
        .sel_i(q.s1.sb), .self_i(q.s2.res),
        .peer_i(peer_res[WORD_W-1:HALF_W]), .load_i(load_res[WORD_W-1:HALF_W]),
        .deep_i(deep_res[WORD_W-1:HALF_W]), .out_o(b_hi)
    );

    stag_alu_slice #(.HALF_W(HALF_W), .LANE_W(LANE_W), .IS_LO(1'b1)) u_slice_lo (
        .a_i(a_lo), .b_i(b_lo), .op_i(in_op), .inv_i(in_inv_b),
        .cin_op_i(in_cin), .cin_ext_i(in_cin),
        .blk_i({in_blk[LPH-2:0], 1'b0}), .sgn_i(a_lo[LANE_W-1]),
        .res_o(lo_sum), .cout_o(lo_cout)
    );

    stag_alu_slice #(.HALF_W(HALF_W), .LANE_W(LANE_W), .IS_LO(1'b0)) u_slice_hi (
        .a_i(a_hi), .b_i(b_hi), .op_i(q.s1.op), .inv_i(q.s1.inv),
        .cin_op_i(q.s1.cin), .cin_ext_i(q.s1.cout),
        .blk_i(q.s1.blk_hi), .sgn_i(q.s1.sgn),
        .res_o(hi_sum), .cout_o(hi_cout)
    );

    assign arith = (q.s2.op == OP_ADD);

    always_comb begin
        d = q;
        // Stage 1: low half
        d.s1.v = in_valid;
        if (in_valid) begin
            d.s1.op     = in_op;
            d.s1.inv    = in_inv_b;
            d.s1.cin    = in_cin;
            d.s1.blk_hi = in_blk[NLANE-2:LPH-1];
            d.s1.sa     = in_sel_a;
            d.s1.sb     = in_sel_b;
            d.s1.sgn    = (in_op == OP_SX8) ? a_lo[LANE_W-1] : a_lo[MSB];
            d.s1.cout   = lo_cout;
            d.s1.res    = lo_sum;
        end
        // Stage 2: high half
        d.s2.v = q.s1.v;
        if (q.s1.v) begin
            d.s2.op      = q.s1.op;
            d.s2.lo_zero = (q.s1.res == '0);
            d.s2.c_out   = hi_cout;
            d.s2.c_msb   = a_hi[MSB] ^ b_hi[MSB] ^ q.s1.inv ^ hi_sum[MSB];
            d.s2.res     = hi_sum;
        end
        // Stage 3: flags
        d.s3.v = q.s2.v;
        if (q.s2.v) begin
            d.s3.c  = arith & q.s2.c_out;
            d.s3.ov = arith & (q.s2.c_out ^ q.s2.c_msb);
            d.s3.z  = q.s2.lo_zero & (q.s2.res == '0);
            d.s3.n  = q.s2.res[MSB];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lo_valid  = q.s1.v;
    assign lo_res    = q.s1.res;
    assign hi_valid  = q.s2.v;
    assign hi_res    = q.s2.res;
    assign flg_valid = q.s3.v;
    assign flg_c     = q.s3.c;
    assign flg_z     = q.s3.z;
    assign flg_n     = q.s3.n;
    assign flg_v     = q.s3.ov;

    p_issue_to_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> lo_valid);

    p_lo_to_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lo_valid |=> hi_valid);

    p_hi_to_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_valid |=> flg_valid);

    p_logic_no_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.s2.v && q.s2.op != OP_ADD) |=> (!flg_c && !flg_v));

    p_high_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_valid && hi_res != '0) |=> !flg_z);

    p_zero_not_neg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flg_z |-> !flg_n);

    p_hold_lo_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(lo_res));

    p_hold_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_valid |=> $stable(hi_res));

endmodule

// File: tb/stag_alu_tb.sv
module stag_alu_tb;

    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] T_ADD = 3'd0, T_AND = 3'd1, T_OR = 3'd2, T_XOR = 3'd3,
                           T_SX8 = 3'd4, T_SX16 = 3'd5, T_PASS = 3'd6;

    typedef struct packed {
        logic [2:0]  op;
        logic        inv;
        logic        cin;
        logic [2:0]  blk;
        logic [1:0]  sa;
        logic [1:0]  sb;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
        logic [3:0]  fl;   // C Z N V
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{T_ADD,  1'b0, 1'b0, 3'b000, 2'd1, 2'd2, 32'h0000FFFF, 32'h00000001, 32'h00010000, 4'b0000, 4'd2},
        '{T_ADD,  1'b0, 1'b0, 3'b000, 2'd3, 2'd1, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 4'b0011, 4'd3},
        '{T_ADD,  1'b1, 1'b1, 3'b000, 2'd2, 2'd3, 32'h00000005, 32'h00000005, 32'h00000000, 4'b1100, 4'd5},
        '{T_ADD,  1'b0, 1'b0, 3'b111, 2'd1, 2'd3, 32'h80FF7F01, 32'h80017F01, 32'h0000FE02, 4'b1001, 4'd6},
        '{T_ADD,  1'b1, 1'b1, 3'b111, 2'd2, 2'd1, 32'h01020304, 32'h01010101, 32'h00010203, 4'b1000, 4'd6},
        '{T_ADD,  1'b0, 1'b0, 3'b010, 2'd3, 2'd2, 32'h0001FFFF, 32'h00000001, 32'h00010000, 4'b0000, 4'd6},
        '{T_ADD,  1'b0, 1'b0, 3'b001, 2'd1, 2'd2, 32'h000000FF, 32'h00000001, 32'h00000000, 4'b0100, 4'd6},
        '{T_ADD,  1'b0, 1'b1, 3'b000, 2'd2, 2'd1, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 4'b1100, 4'd5},
        '{T_AND,  1'b0, 1'b0, 3'b000, 2'd1, 2'd2, 32'hF0F01234, 32'hFF00FF00, 32'hF0001200, 4'b0010, 4'd7},
        '{T_AND,  1'b1, 1'b0, 3'b000, 2'd2, 2'd1, 32'hF0F01234, 32'hFF00FF00, 32'h00F00034, 4'b0000, 4'd5},
        '{T_OR,   1'b0, 1'b0, 3'b000, 2'd3, 2'd1, 32'h00000000, 32'h00000000, 32'h00000000, 4'b0100, 4'd7},
        '{T_OR,   1'b1, 1'b0, 3'b000, 2'd1, 2'd2, 32'h0000FFFF, 32'hFFFF0000, 32'h0000FFFF, 4'b0000, 4'd5},
        '{T_XOR,  1'b0, 1'b0, 3'b000, 2'd1, 2'd3, 32'hAAAA5555, 32'hFFFF0000, 32'h55555555, 4'b0000, 4'd7},
        '{T_XOR,  1'b1, 1'b0, 3'b000, 2'd2, 2'd3, 32'h12345678, 32'h12345678, 32'hFFFFFFFF, 4'b0010, 4'd5},
        '{T_SX8,  1'b0, 1'b0, 3'b000, 2'd1, 2'd2, 32'h00000080, 32'h00000000, 32'hFFFFFF80, 4'b0010, 4'd8},
        '{T_SX8,  1'b0, 1'b0, 3'b000, 2'd3, 2'd2, 32'hFFFFFF7F, 32'h00000000, 32'h0000007F, 4'b0000, 4'd8},
        '{T_SX16, 1'b0, 1'b0, 3'b000, 2'd2, 2'd1, 32'h00008001, 32'h00000000, 32'hFFFF8001, 4'b0010, 4'd8},
        '{T_SX16, 1'b0, 1'b0, 3'b000, 2'd1, 2'd3, 32'hFFFF7FFF, 32'h00000000, 32'h00007FFF, 4'b0000, 4'd8},
        '{T_PASS, 1'b0, 1'b0, 3'b000, 2'd3, 2'd1, 32'hDEADBEEF, 32'h00000000, 32'hDEADBEEF, 4'b0010, 4'd9}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic        in_inv_b = 1'b0;
    logic        in_cin = 1'b0;
    logic [2:0]  in_blk = '0;
    logic [1:0]  in_sel_a = '0;
    logic [1:0]  in_sel_b = '0;
    logic [31:0] peer_res = '0;
    logic [31:0] load_res = '0;
    logic [31:0] deep_res = '0;
    logic        lo_valid, hi_valid, flg_valid;
    logic [15:0] lo_res, hi_res;
    logic        flg_c, flg_z, flg_n, flg_v;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stag_alu u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_inv_b(in_inv_b), .in_cin(in_cin), .in_blk(in_blk),
        .in_sel_a(in_sel_a), .in_sel_b(in_sel_b),
        .peer_res(peer_res), .load_res(load_res), .deep_res(deep_res),
        .lo_valid(lo_valid), .lo_res(lo_res), .hi_valid(hi_valid), .hi_res(hi_res),
        .flg_valid(flg_valid), .flg_c(flg_c), .flg_z(flg_z), .flg_n(flg_n), .flg_v(flg_v)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tname(input logic [3:0] t);
        case (t)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic put_src(input logic [1:0] sel, input logic [31:0] val);
        case (sel)
            2'd1:    peer_res = val;
            2'd2:    load_res = val;
            default: deep_res = val;
        endcase
    endtask

    task automatic run_vec(input int i);
        vec_t v;
        v = VECS[i];
        @(negedge clk);
        peer_res = '0; load_res = '0; deep_res = '0;
        put_src(v.sa, v.a);
        put_src(v.sb, v.b);
        in_valid = 1'b1; in_op = v.op; in_inv_b = v.inv; in_cin = v.cin;
        in_blk = v.blk; in_sel_a = v.sa; in_sel_b = v.sb;
        @(negedge clk);
        in_valid = 1'b0;
        check($sformatf("R1 %s vec%0d lo", tname(v.tag), i), {15'd0, lo_valid, lo_res}, {15'd0, 1'b1, v.exp[15:0]});
        @(negedge clk);
        check($sformatf("R2 %s vec%0d hi", tname(v.tag), i), {15'd0, hi_valid, hi_res}, {15'd0, 1'b1, v.exp[31:16]});
        @(negedge clk);
        check($sformatf("R3 %s vec%0d flags", tname(v.tag), i),
              {27'd0, flg_valid, flg_c, flg_z, flg_n, flg_v}, {27'd0, 1'b1, v.fl});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        // R10: reset state, sampled while reset is held
        @(negedge clk);
        check("R10 valids in reset", {29'd0, lo_valid, hi_valid, flg_valid}, 32'd0);
        check("R10 results in reset", {lo_res, hi_res}, 32'd0);
        check("R10 flags in reset", {28'd0, flg_c, flg_z, flg_n, flg_v}, 32'd0);
        rst_n = 1'b1;

        // Table of single operations
        for (int i = 0; i < NV; i++) run_vec(i);

        // R11: idle, sources change, everything holds the PASS result
        @(negedge clk);
        peer_res = 32'h13579BDF; load_res = 32'h2468ACE0; deep_res = 32'hFFFFFFFF;
        in_sel_a = 2'd3; in_op = T_ADD;
        repeat (3) @(negedge clk);
        check("R11 valids low when idle", {29'd0, lo_valid, hi_valid, flg_valid}, 32'd0);
        check("R11 result held", {hi_res, lo_res}, 32'hDEADBEEF);
        check("R11 flags held", {28'd0, flg_c, flg_z, flg_n, flg_v}, 32'h2);

        // R4: three dependent adds on consecutive cycles via own result
        @(negedge clk);
        in_op = T_ADD; in_inv_b = 1'b0; in_cin = 1'b0; in_blk = 3'b000;
        peer_res = 32'h0000FFFF; load_res = 32'h00000001; deep_res = '0;
        in_valid = 1'b1; in_sel_a = 2'd1; in_sel_b = 2'd2;
        @(negedge clk);
        check("R4 op1 lo", {16'd0, lo_res}, 32'h0000);
        in_sel_a = 2'd0; in_sel_b = 2'd2;
        @(negedge clk);
        check("R4 op2 lo from own lo", {16'd0, lo_res}, 32'h0001);
        check("R4 op1 hi with carry", {16'd0, hi_res}, 32'h0001);
        load_res = 32'h0000FFFF;
        @(negedge clk);
        in_valid = 1'b0;
        check("R4 op3 lo back to back", {15'd0, lo_valid, lo_res}, {15'd0, 1'b1, 16'h0000});
        check("R4 op2 hi from own hi", {16'd0, hi_res}, 32'h0001);
        check("R4 op1 flags", {27'd0, flg_valid, flg_c, flg_z, flg_n, flg_v}, 32'h10);
        @(negedge clk);
        check("R4 op3 hi own hi plus carry", {15'd0, hi_valid, hi_res}, {15'd0, 1'b1, 16'h0002});
        check("R4 op2 flags", {27'd0, flg_valid, flg_c, flg_z, flg_n, flg_v}, 32'h10);
        @(negedge clk);
        check("R4 op3 flags", {27'd0, flg_valid, flg_c, flg_z, flg_n, flg_v}, 32'h10);
        check("R4 valids drain", {30'd0, lo_valid, hi_valid}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule